// File: doc/BRIEF.md
# Time-Aligned Periodic Clock-Out Generator

This block produces a square wave on an output pin whose edges are scheduled against a free-running fractional system-time counter rather than derived by dividing a clock. Software programs a first-edge time (normally the next whole second, in scaled counter units) and an interval (one second in the same units, that is 10^9 shifted left by the active scale shift). Once the block is armed, the pin flips each time system time reaches the scheduled time, and the schedule then moves forward by one interval. Because the comparison is made against the adjustable time counter, the phase of the wave follows any rate or offset correction applied to that counter.

The generator runs only when four bits are all set: clock-out enable, synchronise-to-time, pin-as-output and pin-native-function. Clearing any of them disarms it. While disarmed the pin keeps its last level. Each time the generator arms, it reloads the first-edge time from the target input. Software clears the control bits before it re-bases the time counter, for example on a link speed change, and re-arms afterwards. An optional interrupt pulse marks every level change.

The controller is a two-state machine. In IDLE it waits for all four enabling bits. The ARM transition, IDLE to ARMED, latches the target. In ARMED the FIRE transition (ARMED to ARMED) flips the pin and advances the target whenever system time is at or past it. The DISARM transition, ARMED to IDLE, is taken as soon as any enabling bit drops.

Top module: `clkout_gen`

## Requirements
- R1: During and after reset, clk_out, clk_out_irq and clk_out_oe are all 0.
- R2: The pin never changes level unless ctl_en, ctl_sync, cfg_pin_out and cfg_pin_native were all 1 at the edge where it changes. With any one of them 0, the pin stays put even when system time is past the target.
- R3: The edge where all four enabling bits are first seen 1 arms the block and latches target_time. If sys_time >= that target, the pin toggles on the very next clock edge.
- R4: After each toggle the scheduled time becomes the previous scheduled time plus period_time. The next toggle happens at the first edge where sys_time is greater than or equal to the new value.
- R5: When ctl_irq_en is 1, clk_out_irq is high for exactly the one cycle in which clk_out has just changed level, and it is low otherwise.
- R6: When ctl_irq_en is 0, clk_out_irq stays 0 even though the pin keeps toggling.
- R7: While disarmed the pin holds its last level, whether that is high or low.
- R8: Re-arming reloads the schedule from target_time and discards the old scheduled time.
- R9: The comparison includes equality: sys_time equal to the scheduled time causes a toggle.
- R10: clk_out_oe is 1 exactly when all four enabling bits are 1, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Fractional system-time counter value |
| target_time | input | 64 | First-edge time, loaded when the block arms |
| period_time | input | 64 | Interval added after each edge |
| ctl_en | input | 1 | Clock-out enable |
| ctl_sync | input | 1 | Synchronise-to-time select |
| ctl_irq_en | input | 1 | Interrupt on each level change |
| cfg_pin_out | input | 1 | Pin configured as output |
| cfg_pin_native | input | 1 | Pin routed to its native function |
| clk_out | output | 1 | Generated pin level |
| clk_out_oe | output | 1 | Pin drive enable / native select |
| clk_out_irq | output | 1 | One-cycle interrupt pulse per level change |

## Verification
The embedded assertions check on every cycle that the pin moves only when the block was fully enabled, that it holds while disarmed, that each interrupt pulse coincides with a level change and an enabled interrupt, and that the schedule advances by exactly one interval or reloads on arming. The bench's scenarios show what these per-cycle checks cannot. They show the exact edge of each toggle relative to the target, including the equality case and a target already in the past. They show that each of the four enabling bits gates the output on its own, and that a re-arm with a future target suppresses toggles that the stale schedule would have produced.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
    typedef enum logic [0:0] {
        CO_IDLE  = 1'b0,
        CO_ARMED = 1'b1
    } co_state_t;
endpackage

// File: rtl/clkout_enable_decode.sv
module clkout_enable_decode (
    input  logic ctl_en,
    input  logic ctl_sync,
    input  logic cfg_pin_out,
    input  logic cfg_pin_native,
    output logic active
);
    always_comb begin
        active = ctl_en & ctl_sync & cfg_pin_out & cfg_pin_native;
    end
endmodule

// File: rtl/clkout_target_tracker.sv
module clkout_target_tracker #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [TIME_W-1:0] target_time,
    input  logic [TIME_W-1:0] period_time,
    input  logic [TIME_W-1:0] sys_time,
    output logic              due
);
    logic [TIME_W-1:0] sched_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_q <= '0;
        end else if (load) begin
            sched_q <= target_time;
        end else if (advance) begin
            sched_q <= sched_q + period_time;
        end
    end

    always_comb begin
        due = (sys_time >= sched_q);
    end

    // R4
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (sched_q == $past(sched_q) + $past(period_time)));

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sched_q == $past(target_time)));
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [TIME_W-1:0] target_time,
    input  logic [TIME_W-1:0] period_time,
    input  logic              ctl_en,
    input  logic              ctl_sync,
    input  logic              ctl_irq_en,
    input  logic              cfg_pin_out,
    input  logic              cfg_pin_native,
    output logic              clk_out,
    output logic              clk_out_oe,
    output logic              clk_out_irq
);
    co_state_t state_q, state_d;
    logic      active;
    logic      due;
    logic      arm_ev;
    logic      fire_ev;

    clkout_enable_decode u_decode (
        .ctl_en         (ctl_en),
        .ctl_sync       (ctl_sync),
        .cfg_pin_out    (cfg_pin_out),
        .cfg_pin_native (cfg_pin_native),
        .active         (active)
    );

    clkout_target_tracker #(.TIME_W(TIME_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (arm_ev),
        .advance     (fire_ev),
        .target_time (target_time),
        .period_time (period_time),
        .sys_time    (sys_time),
        .due         (due)
    );

    always_comb begin
        state_d = state_q;
        arm_ev  = 1'b0;
        fire_ev = 1'b0;
        unique case (state_q)
            CO_IDLE: begin
                if (active) begin
                    state_d = CO_ARMED;
                    arm_ev  = 1'b1;
                end
            end
            CO_ARMED: begin
                if (!active) begin
                    state_d = CO_IDLE;
                end else if (due) begin
                    fire_ev = 1'b1;
                end
            end
            default: state_d = CO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_out     <= 1'b0;
            clk_out_irq <= 1'b0;
        end else begin
            clk_out     <= clk_out ^ fire_ev;
            clk_out_irq <= fire_ev & ctl_irq_en;
        end
    end

    assign clk_out_oe = active;

    // R2
    toggle_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out != $past(clk_out)) |-> $past(active));

    // R7
    hold_while_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> $stable(clk_out));

    // R5
    irq_needs_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out_irq |-> (clk_out != $past(clk_out)));

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out_irq |-> $past(ctl_irq_en));
endmodule

// File: tb/clkout_gen_tb.sv
`timescale 1ns/1ps
module clkout_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = '0;
    logic [63:0] target_time = '0;
    logic [63:0] period_time = '0;
    logic        ctl_en = 1'b0;
    logic        ctl_sync = 1'b0;
    logic        ctl_irq_en = 1'b0;
    logic        cfg_pin_out = 1'b0;
    logic        cfg_pin_native = 1'b0;
    logic        clk_out;
    logic        clk_out_oe;
    logic        clk_out_irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    clkout_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sys_time       (sys_time),
        .target_time    (target_time),
        .period_time    (period_time),
        .ctl_en         (ctl_en),
        .ctl_sync       (ctl_sync),
        .ctl_irq_en     (ctl_irq_en),
        .cfg_pin_out    (cfg_pin_out),
        .cfg_pin_native (cfg_pin_native),
        .clk_out        (clk_out),
        .clk_out_oe     (clk_out_oe),
        .clk_out_irq    (clk_out_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_bits(input logic [3:0] b);
        {ctl_en, ctl_sync, cfg_pin_out, cfg_pin_native} = b;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        // R1
        chk("R1 pin", clk_out, 0);
        chk("R1 irq", clk_out_irq, 0);
        chk("R1 oe", clk_out_oe, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 pin after release", clk_out, 0);
    endtask

    task automatic t_gating();
        target_time = 64'd100;
        period_time = 64'd50;
        ctl_irq_en  = 1'b1;
        sys_time    = 64'd500;
        for (int i = 0; i < 4; i++) begin
            set_bits(4'b1111 & ~(4'b0001 << i));
            repeat (3) tick();
            // R2
            chk("R2 pin gated", clk_out, 0);
            // R10
            chk("R10 oe gated", clk_out_oe, 0);
        end
        sys_time = 64'd0;
        set_bits(4'b1111);
        #1;
        chk("R10 oe immediate", clk_out_oe, 1);
        tick();
        chk("R3 no toggle on arm edge", clk_out, 0);
    endtask

    task automatic t_schedule();
        sys_time = 64'd90;  tick();
        chk("R3 before target", clk_out, 0);
        sys_time = 64'd99;  tick();
        chk("R9 one below", clk_out, 0);
        sys_time = 64'd100; tick();
        // R9 equality fires
        chk("R9 equal toggles", clk_out, 1);
        chk("R5 irq pulse", clk_out_irq, 1);
        tick();
        chk("R4 no retrigger", clk_out, 1);
        chk("R5 irq one cycle", clk_out_irq, 0);
        sys_time = 64'd149; tick();
        chk("R4 before next", clk_out, 1);
        sys_time = 64'd150; tick();
        chk("R4 second edge", clk_out, 0);
        chk("R5 second irq", clk_out_irq, 1);
        sys_time = 64'd200; tick();
        chk("R4 third edge", clk_out, 1);
    endtask

    task automatic t_irq_mask();
        ctl_irq_en = 1'b0;
        sys_time = 64'd250; tick();
        // R6
        chk("R6 toggles", clk_out, 0);
        chk("R6 irq masked", clk_out_irq, 0);
        sys_time = 64'd300; tick();
        chk("R6 toggles high", clk_out, 1);
        chk("R6 irq masked high", clk_out_irq, 0);
    endtask

    task automatic t_disable_hold();
        ctl_en = 1'b0;
        sys_time = 64'd1000;
        repeat (3) tick();
        // R7
        chk("R7 holds high", clk_out, 1);
        chk("R7 oe off", clk_out_oe, 0);
        chk("R7 no irq", clk_out_irq, 0);
    endtask

    task automatic t_reenable_reload();
        target_time = 64'd8000;
        period_time = 64'd1000;
        sys_time    = 64'd6000;
        ctl_irq_en  = 1'b1;
        ctl_en      = 1'b1;
        tick();
        tick();
        tick();
        // R8 stale schedule would have toggled here
        chk("R8 future target no toggle", clk_out, 1);
        sys_time = 64'd8000; tick();
        chk("R8 toggles at new target", clk_out, 0);
        chk("R8 irq", clk_out_irq, 1);
    endtask

    task automatic t_past_target();
        ctl_en = 1'b0;
        tick();
        target_time = 64'd100;
        period_time = 64'd10000;
        sys_time    = 64'd9000;
        ctl_en      = 1'b1;
        tick();
        chk("R3 arm edge", clk_out, 0);
        tick();
        // R3 past target toggles next cycle
        chk("R3 past target toggle", clk_out, 1);
        tick();
        chk("R4 after catch-up", clk_out, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_gating();
        t_schedule();
        t_irq_mask();
        t_disable_hold();
        t_reenable_reload();
        t_past_target();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule